// File: doc/BRIEF.md
# Latency-QoS Priority Pool Arbiter

This block decides which of several hosts may use one shared client port. Each host has a small configuration slot holding a two-bit priority and a latency-QoS enable. When the enable is clear, the host competes at its programmed priority. When the enable is set, the host supplies a two-bit latency level of its own, and that level is capped at the programmed priority. The resulting value is the host's effective priority.

Requesting hosts with the same effective priority form a pool, and the highest non-empty pool wins. Pools 0 and 3 rotate fairly among their members. Each of these two pools keeps its own rotation pointer. Pools 1 and 2 always favour the lowest host index.

The winner gets a registered one-hot grant, together with the effective priority it won at, which is forwarded to the client. The grant stays in place until the granted host signals the end of its transfer. The configuration slots are written as one word, and that write is dropped while the write-protect input is high.

Top module: `qos_pool_arbiter`

## Requirements
- R1: After synchronous reset, `gnt` is 0, `gnt_valid` is 0, `gnt_prio` is 0, every configuration slot reads as 0 (the default reset value), and both rotation pointers point at host 0.
- R2: Host h owns bits [4h+3:4h] of `cfg_wr_data` and `cfg_rd_data`. Bits [1:0] are the priority, bit 2 is the QoS enable, and bit 3 always reads 0. A write with `cfg_wr_en`=1 and `cfg_wp_en`=0 takes effect at the next clock edge.
- R3: A write while `cfg_wp_en`=1 leaves every slot unchanged, in both the read-back value and the arbitration results.
- R4: The effective priority of host h is its programmed priority when its QoS enable is 0. When the enable is 1, it is the smaller of `qos_lvl[2h+1:2h]` and the programmed priority.
- R5: Among the requesting hosts, only those in the highest effective-priority pool can win. `gnt_prio` shows that pool's value for as long as the grant is held.
- R6: In pools 1 and 2, the requesting member with the lowest index wins.
- R7: In pools 0 and 3, the winner is the first requesting member found from that pool's pointer upward, wrapping to host 0 after the top index. A grant from the pool moves its pointer to the winner's index plus one, modulo the host count. Grants from other pools leave the pointer unchanged.
- R8: When no grant is held and at least one request is present, a one-hot grant to a requesting host appears after the next clock edge, and `gnt_valid` rises with it.
- R9: While a grant is held, changes to `req`, `qos_lvl` and the configuration, and `xfer_done` from other hosts, leave `gnt` and `gnt_prio` unchanged.
- R10: `xfer_done` from the granted host clears `gnt`, `gnt_valid` and `gnt_prio` at the next edge. Arbitration resumes at the edge after that.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr_en | input | 1 | Write strobe for all configuration slots |
| cfg_wp_en | input | 1 | Write protect; blocks writes while high |
| cfg_wr_data | input | 4*N_HOSTS | New configuration, one 4-bit slot per host |
| cfg_rd_data | output | 4*N_HOSTS | Current configuration, bit 3 of each slot reads 0 |
| req | input | N_HOSTS | Request, one bit per host |
| qos_lvl | input | 2*N_HOSTS | Latency level supplied by each host |
| xfer_done | input | N_HOSTS | End of transfer, one bit per host |
| gnt | output | N_HOSTS | One-hot grant |
| gnt_valid | output | 1 | A grant is held |
| gnt_prio | output | 2 | Effective priority of the granted host, forwarded to the client |

## Verification
A wrong rotation pointer does not fail at once. It shows up only at the next grant from that same pool, as a different winner among tied requesters, so the sweep repeats each request pattern back-to-back within a pool. A faulty QoS cap or pool selection shows at the very next grant, either on `gnt` or on `gnt_prio`. A broken hold or release shows within one cycle: the grant moves while other hosts change their inputs, or it stays up after the end of the transfer. A write-protect fault shows on the read-back word one cycle after the blocked write.

// File: rtl/qpa_pkg.sv
package qpa_pkg;

    localparam int PRIO_W     = 2;
    localparam int CFG_SLOT_W = 4;
    localparam int QOS_W      = 2;

    typedef logic [PRIO_W-1:0] prio_t;

    // per-host configuration slot, packed as {qos_en, prio}
    typedef struct packed {
        logic  qos_en;
        prio_t prio;
    } host_cfg_t;

    localparam int CFG_USED_W = $bits(host_cfg_t);

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_XFER = 1'b1
    } arb_state_t;

    // effective priority: programmed value, or host level capped by it
    function automatic prio_t effective_prio(host_cfg_t c, prio_t lvl);
        if (!c.qos_en)
            return c.prio;
        return (lvl < c.prio) ? lvl : c.prio;
    endfunction

    // only the lowest and highest pools rotate
    function automatic logic pool_rotates(prio_t p);
        return (p == '0) || (p == '1);
    endfunction

endpackage

// File: rtl/qpa_cfg_reg.sv
module qpa_cfg_reg
    import qpa_pkg::*;
#(
    parameter int          N_HOSTS  = 4,
    parameter logic [3:0]  RST_SLOT = 4'h0
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic                         wp_en,
    input  logic [N_HOSTS*CFG_SLOT_W-1:0] wr_data,
    output host_cfg_t [N_HOSTS-1:0]      cfg,
    output logic [N_HOSTS*CFG_SLOT_W-1:0] rd_data
);

    localparam host_cfg_t RST_CFG = host_cfg_t'(RST_SLOT[CFG_USED_W-1:0]);

    logic wr_ok;
    assign wr_ok = wr_en && !wp_en;

    for (genvar h = 0; h < N_HOSTS; h++) begin : g_slot
        host_cfg_t slot_q;

        always_ff @(posedge clk) begin
            if (rst)
                slot_q <= RST_CFG;
            else if (wr_ok)
                slot_q <= host_cfg_t'(wr_data[h*CFG_SLOT_W +: CFG_USED_W]);
        end

        assign cfg[h] = slot_q;
        assign rd_data[h*CFG_SLOT_W +: CFG_SLOT_W] =
            {{(CFG_SLOT_W-CFG_USED_W){1'b0}}, slot_q};
    end

    // R3: a protected write leaves the stored configuration alone
    p_wp_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wp_en) |=> $stable(rd_data));

    // R2: an unprotected write shows up at the next edge
    p_wr_apply_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wp_en) |=> (cfg == $past(cfg_from_bus(wr_data))));

    function automatic logic [N_HOSTS*CFG_USED_W-1:0]
        cfg_from_bus(logic [N_HOSTS*CFG_SLOT_W-1:0] d);
        logic [N_HOSTS*CFG_USED_W-1:0] r;
        for (int h = 0; h < N_HOSTS; h++)
            r[h*CFG_USED_W +: CFG_USED_W] = d[h*CFG_SLOT_W +: CFG_USED_W];
        return r;
    endfunction

endmodule

// File: rtl/qpa_prio_eval.sv
module qpa_prio_eval
    import qpa_pkg::*;
#(
    parameter int N_HOSTS = 4
) (
    input  host_cfg_t [N_HOSTS-1:0]      cfg,
    input  logic [N_HOSTS-1:0]           req,
    input  logic [N_HOSTS*QOS_W-1:0]     qos_lvl,
    output prio_t [N_HOSTS-1:0]          eff,
    output prio_t                        top_pool,
    output logic [N_HOSTS-1:0]           pool_mask,
    output logic                         any_req
);

    for (genvar h = 0; h < N_HOSTS; h++) begin : g_eff
        assign eff[h] = effective_prio(cfg[h], prio_t'(qos_lvl[h*QOS_W +: QOS_W]));
    end

    assign any_req = |req;

    always_comb begin
        top_pool = '0;
        for (int h = 0; h < N_HOSTS; h++) begin
            if (req[h] && (eff[h] > top_pool))
                top_pool = eff[h];
        end
    end

    always_comb begin
        for (int h = 0; h < N_HOSTS; h++)
            pool_mask[h] = req[h] && (eff[h] == top_pool);
    end

endmodule

// File: rtl/qpa_pool_pick.sv
module qpa_pool_pick
    import qpa_pkg::*;
#(
    parameter int N_HOSTS = 4,
    parameter int IDX_W   = 2
) (
    input  logic [N_HOSTS-1:0] cand,
    input  prio_t              pool,
    input  logic [IDX_W-1:0]   ptr_lo,
    input  logic [IDX_W-1:0]   ptr_hi,
    output logic [N_HOSTS-1:0] win_oh,
    output logic [IDX_W-1:0]   win_idx
);

    int   start;
    int   idx;
    logic found;

    // fixed pools search from host 0, rotating pools from their pointer
    always_comb begin
        if (!pool_rotates(pool))
            start = 0;
        else if (pool == '0)
            start = int'(ptr_lo);
        else
            start = int'(ptr_hi);
    end

    always_comb begin
        found   = 1'b0;
        win_oh  = '0;
        win_idx = '0;
        for (int k = 0; k < N_HOSTS; k++) begin
            idx = start + k;
            if (idx >= N_HOSTS)
                idx = idx - N_HOSTS;
            if (!found && cand[idx]) begin
                found       = 1'b1;
                win_oh[idx] = 1'b1;
                win_idx     = IDX_W'(idx);
            end
        end
    end

endmodule

// File: rtl/qos_pool_arbiter.sv
module qos_pool_arbiter
    import qpa_pkg::*;
#(
    parameter int         N_HOSTS      = 4,
    parameter logic [3:0] CFG_RST_SLOT = 4'h0
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          cfg_wr_en,
    input  logic                          cfg_wp_en,
    input  logic [N_HOSTS*CFG_SLOT_W-1:0] cfg_wr_data,
    output logic [N_HOSTS*CFG_SLOT_W-1:0] cfg_rd_data,
    input  logic [N_HOSTS-1:0]            req,
    input  logic [N_HOSTS*QOS_W-1:0]      qos_lvl,
    input  logic [N_HOSTS-1:0]            xfer_done,
    output logic [N_HOSTS-1:0]            gnt,
    output logic                          gnt_valid,
    output logic [PRIO_W-1:0]             gnt_prio
);

    localparam int IDX_W = (N_HOSTS > 1) ? $clog2(N_HOSTS) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_HOSTS - 1);

    host_cfg_t [N_HOSTS-1:0] cfg;
    prio_t     [N_HOSTS-1:0] eff;
    prio_t                   top_pool;
    logic [N_HOSTS-1:0]      pool_mask;
    logic                    any_req;
    logic [N_HOSTS-1:0]      win_oh;
    logic [IDX_W-1:0]        win_idx;
    logic [IDX_W-1:0]        win_next;

    arb_state_t              state_q;
    logic [N_HOSTS-1:0]      gnt_q;
    prio_t                   gnt_prio_q;
    logic [IDX_W-1:0]        gnt_idx_q;
    logic [IDX_W-1:0]        rr_lo_q;
    logic [IDX_W-1:0]        rr_hi_q;
    logic                    owner_done;

    qpa_cfg_reg #(
        .N_HOSTS  (N_HOSTS),
        .RST_SLOT (CFG_RST_SLOT)
    ) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_wr_en),
        .wp_en   (cfg_wp_en),
        .wr_data (cfg_wr_data),
        .cfg     (cfg),
        .rd_data (cfg_rd_data)
    );

    qpa_prio_eval #(
        .N_HOSTS (N_HOSTS)
    ) u_eval (
        .cfg       (cfg),
        .req       (req),
        .qos_lvl   (qos_lvl),
        .eff       (eff),
        .top_pool  (top_pool),
        .pool_mask (pool_mask),
        .any_req   (any_req)
    );

    qpa_pool_pick #(
        .N_HOSTS (N_HOSTS),
        .IDX_W   (IDX_W)
    ) u_pick (
        .cand    (pool_mask),
        .pool    (top_pool),
        .ptr_lo  (rr_lo_q),
        .ptr_hi  (rr_hi_q),
        .win_oh  (win_oh),
        .win_idx (win_idx)
    );

    assign win_next   = (win_idx == LAST_IDX) ? '0 : win_idx + 1'b1;
    assign owner_done = xfer_done[gnt_idx_q];

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            gnt_q      <= '0;
            gnt_prio_q <= '0;
            gnt_idx_q  <= '0;
            rr_lo_q    <= '0;
            rr_hi_q    <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (any_req) begin
                        state_q    <= ST_XFER;
                        gnt_q      <= win_oh;
                        gnt_prio_q <= top_pool;
                        gnt_idx_q  <= win_idx;
                        if (top_pool == '0)
                            rr_lo_q <= win_next;
                        if (top_pool == '1)
                            rr_hi_q <= win_next;
                    end
                end
                ST_XFER: begin
                    if (owner_done) begin
                        state_q    <= ST_IDLE;
                        gnt_q      <= '0;
                        gnt_prio_q <= '0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign gnt       = gnt_q;
    assign gnt_valid = (state_q == ST_XFER);
    assign gnt_prio  = gnt_prio_q;

    // R8: never more than one host granted
    p_gnt_onehot_r8: assert property (@(posedge clk) disable iff (rst)
        $onehot0(gnt_q));

    // R8: the valid flag and the grant vector agree
    p_valid_match_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_XFER) == (gnt_q != '0));

    // R8: an idle arbiter with requests grants one of the requesters
    p_grant_req_r8: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_IDLE && req != '0) |=> ((gnt_q & $past(req)) != '0));

    // R9: the grant and its priority stay put until the owner finishes
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_XFER && !owner_done) |=> ($stable(gnt_q) && $stable(gnt_prio_q)));

    // R10: the owner's done releases the grant at the next edge
    p_release_r10: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_XFER && owner_done) |=> (gnt_q == '0 && gnt_prio_q == '0));

    // R7: the low pool pointer moves only on a grant from pool 0
    p_lo_ptr_r7: assert property (@(posedge clk) disable iff (rst)
        !(state_q == ST_IDLE && any_req && top_pool == '0) |=> $stable(rr_lo_q));

    // R7: the high pool pointer moves only on a grant from pool 3
    p_hi_ptr_r7: assert property (@(posedge clk) disable iff (rst)
        !(state_q == ST_IDLE && any_req && top_pool == '1) |=> $stable(rr_hi_q));

endmodule

// File: tb/tb_qos_pool_arbiter.sv
module tb_qos_pool_arbiter;

    localparam int N = 4;

    logic           clk = 1'b0;
    logic           rst;
    logic           cfg_wr_en;
    logic           cfg_wp_en;
    logic [4*N-1:0] cfg_wr_data;
    logic [4*N-1:0] cfg_rd_data;
    logic [N-1:0]   req;
    logic [2*N-1:0] qos_lvl;
    logic [N-1:0]   xfer_done;
    logic [N-1:0]   gnt;
    logic           gnt_valid;
    logic [1:0]     gnt_prio;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    int cur_cfg = 0;
    int rrp[4];

    always #4 clk = ~clk;

    qos_pool_arbiter #(.N_HOSTS(N)) dut (
        .clk         (clk),
        .rst         (rst),
        .cfg_wr_en   (cfg_wr_en),
        .cfg_wp_en   (cfg_wp_en),
        .cfg_wr_data (cfg_wr_data),
        .cfg_rd_data (cfg_rd_data),
        .req         (req),
        .qos_lvl     (qos_lvl),
        .xfer_done   (xfer_done),
        .gnt         (gnt),
        .gnt_valid   (gnt_valid),
        .gnt_prio    (gnt_prio)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic int eff_of(int c, int q, int h);
        int pr  = (c >> (4*h)) & 3;
        int qen = (c >> (4*h + 2)) & 1;
        int lv  = (q >> (2*h)) & 3;
        if (qen == 0) return pr;
        return (lv < pr) ? lv : pr;
    endfunction

    task automatic write_cfg(input int val, input bit prot);
        @(negedge clk);
        cfg_wp_en   = prot;
        cfg_wr_en   = 1'b1;
        cfg_wr_data = val[4*N-1:0];
        @(negedge clk);
        cfg_wr_en   = 1'b0;
        cfg_wp_en   = 1'b0;
        if (!prot) cur_cfg = val & 32'h7777;
    endtask

    // one full grant cycle: request, hold under disturbance, release
    task automatic arbitrate(input int rq, input int qv);
        int top = -1;
        int start;
        int w = -1;
        int exp_oh;
        for (int h = 0; h < N; h++)
            if (((rq >> h) & 1) != 0 && eff_of(cur_cfg, qv, h) > top)
                top = eff_of(cur_cfg, qv, h);
        start = (top == 1 || top == 2) ? 0 : rrp[top];
        for (int k = 0; k < N; k++) begin
            int idx = (start + k) % N;
            if (w < 0 && ((rq >> idx) & 1) != 0 && eff_of(cur_cfg, qv, idx) == top)
                w = idx;
        end
        exp_oh = 1 << w;
        if (top == 0 || top == 3) rrp[top] = (w + 1) % N;

        req     = rq[N-1:0];
        qos_lvl = qv[2*N-1:0];
        @(negedge clk);
        if (top == 1 || top == 2)
            chk(gnt == exp_oh[N-1:0], "R6 fixed-order winner", int'(gnt), exp_oh);
        else
            chk(gnt == exp_oh[N-1:0], "R7 rotating winner", int'(gnt), exp_oh);
        chk(gnt_prio == top[1:0], "R4/R5 forwarded priority", int'(gnt_prio), top);
        chk(gnt_valid == 1'b1, "R8 grant valid", int'(gnt_valid), 1);

        // disturb: flip requests and levels, other hosts signal done
        req       = ~rq[N-1:0];
        qos_lvl   = ~qv[2*N-1:0];
        xfer_done = ~exp_oh[N-1:0];
        @(negedge clk);
        chk(gnt == exp_oh[N-1:0] && gnt_prio == top[1:0], "R9 grant held",
            int'({gnt_prio, gnt}), int'({top[1:0], exp_oh[N-1:0]}));

        xfer_done = exp_oh[N-1:0];
        req       = '0;
        @(negedge clk);
        chk(gnt == '0 && gnt_valid == 1'b0 && gnt_prio == 2'd0, "R10 release",
            int'({gnt_valid, gnt_prio, gnt}), 0);
        xfer_done = '0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog R8: run did not complete, actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int cfgs[5] = '{32'h0000, 32'h3333, 32'h1212, 32'h7654, 32'h3607};
        int qpat[4] = '{32'h00, 32'hFF, 32'hE4, 32'h1B};
        for (int p = 0; p < 4; p++) rrp[p] = 0;
        rst = 1'b1; cfg_wr_en = 1'b0; cfg_wp_en = 1'b0; cfg_wr_data = '0;
        req = '0; qos_lvl = '0; xfer_done = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(gnt == '0, "R1 reset grant", int'(gnt), 0);
        chk(gnt_valid == 1'b0, "R1 reset valid", int'(gnt_valid), 0);
        chk(gnt_prio == 2'd0, "R1 reset priority", int'(gnt_prio), 0);
        chk(cfg_rd_data == '0, "R1 reset configuration", int'(cfg_rd_data), 0);

        // R1: pointers start at host 0, all hosts in pool 0
        arbitrate(32'hF, 0);
        arbitrate(32'hF, 0);

        // R2: unused bit of every slot reads back 0
        write_cfg(32'hFFFF, 1'b0);
        chk(cfg_rd_data == 16'h7777, "R2 slot layout", int'(cfg_rd_data), 32'h7777);

        // R3: protected write is dropped, arbitration keeps old settings
        write_cfg(32'h0000, 1'b1);
        chk(cfg_rd_data == 16'h7777, "R3 protected write", int'(cfg_rd_data), 32'h7777);
        arbitrate(32'hF, 32'hFF);
        arbitrate(32'h6, 32'h1B);

        // R4-style sweep over configurations, requests and levels
        for (int c = 0; c < 5; c++) begin
            write_cfg(cfgs[c], 1'b0);
            chk(int'(cfg_rd_data) == (cfgs[c] & 32'h7777), "R2 readback",
                int'(cfg_rd_data), cfgs[c] & 32'h7777);
            for (int q = 0; q < 4; q++)
                for (int r = 1; r < 16; r++) begin
                    arbitrate(r, qpat[q]);
                    arbitrate(r, qpat[q]);
                end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule